// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a bytewide asynchronous static RAM of 2048 locations. The host hands it one word at a time through a valid/ready request port that carries an address, write data and a write flag. The controller turns each request into one bus cycle, with active-low chip enable, write enable and output enable strobes. For a read it returns the byte as a one-cycle response pulse. The data bus is split into a drive value, a drive enable and an input value, so a pad cell outside the block can form the shared bidirectional bus.

Every timing limit of the memory is a parameter in nanoseconds: access time, output-enable-to-data time, write pulse width, data setup, write recovery and minimum cycle time. Each limit is rounded up to whole clock cycles using the clock period parameter. A state machine with six states then sequences the strobes from those counts. The states are S_IDLE, S_RD_OPEN, S_RD_WAIT, S_WR_SETUP, S_WR_PULSE and S_RECOVER. The transitions are: accept-read (S_IDLE to S_RD_OPEN), open-done (S_RD_OPEN to S_RD_WAIT), sample (S_RD_WAIT to S_RECOVER), accept-write (S_IDLE to S_WR_SETUP), setup-done (S_WR_SETUP to S_WR_PULSE), window-close (S_WR_PULSE to S_RECOVER) and recovered (S_RECOVER to S_IDLE). All strobe pins come straight from registers.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0 and rsp_valid is 0.
- R2: An accepted read keeps sram_we_n high. It first spends one cycle with sram_ce_n low and sram_oe_n high, then holds sram_oe_n low for exactly L_RD = max(NACC-1, NOE, 1) cycles, where NACC and NOE are the access and output-enable times in cycles.
- R3: Read data is captured at the clock edge that ends the output-enable window. rsp_valid is high for exactly one cycle, starting at the edge 1+L_RD cycles after the accepting edge, with rsp_rdata holding the byte that was read.
- R4: An accepted write first spends one cycle with all strobes high and the drivers enabled. It then holds sram_ce_n and sram_we_n low together for exactly L_WR = max(NWP, NDS-1, 1) cycles, with sram_addr and sram_dq_o unchanged from the setup cycle to the end of the window.
- R5: sram_oe_n is high in every cycle in which sram_we_n is low.
- R6: sram_dq_oe is 0 in every cycle in which sram_oe_n is low, and also in the cycle before sram_oe_n falls.
- R7: After each read or write window, all strobes stay high for REC = max(NWR, NCYC-(busy cycles before recovery), 1) cycles before S_IDLE. The time between successive chip-enable falling edges is never below NCYC.
- R8: req_ready is high only in S_IDLE. A request presented while req_ready is low is ignored and does not change memory.
- R9: Each cycle count is the nanosecond parameter divided by CLK_PERIOD_NS, rounded up. With an 8 ns clock, a read keeps req_ready low for 15 cycles and a write keeps it low for 13 cycles.
- R10: A byte written to an address is returned by later reads of that address, while other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (11) | Word address |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW (8) | Read data |
| sram_addr | output | AW (11) | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_o | output | DW (8) | Data driven toward the memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_i | input | DW (8) | Data returned from the memory |

## Verification
The bench uses an 8 ns clock. At that period a read response is due at the edge 13 cycles after the accepting edge, and req_ready comes back 15 cycles (read) or 13 cycles (write) after acceptance. When the driver issues a read, it queues the expected byte together with its due cycle number. The monitor samples on falling edges and checks both the byte and the arrival cycle. The bench's memory model returns valid data only after chip enable and output enable have been low for the access and output-enable counts. It commits a write only if the window and data setup counts were met, so a design that strobes one cycle short produces wrong read-back data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_OPEN,
        S_RD_WAIT,
        S_WR_SETUP,
        S_WR_PULSE,
        S_RECOVER
    } ctrl_state_e;

    // Rounded-up conversion of a nanosecond limit into clock cycles.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_io.sv
module sram_bus_io #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_wdata,
    input  logic          sample,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          rsp_q
);

    // Address and write data are frozen from acceptance to the next acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            addr_q  <= cap_addr;
            wdata_q <= cap_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= sample;
            if (sample) begin
                rdata_q <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW            = 11,
    parameter int DW            = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACC_NS      = 100,
    parameter int T_OE_NS       = 50,
    parameter int T_WP_NS       = 75,
    parameter int T_DS_NS       = 40,
    parameter int T_WR_NS       = 10,
    parameter int T_CYC_NS      = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [DW-1:0] sram_dq_o,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_i
);

    localparam int NACC  = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
    localparam int NOE   = ns_to_cyc(T_OE_NS,  CLK_PERIOD_NS);
    localparam int NWP   = ns_to_cyc(T_WP_NS,  CLK_PERIOD_NS);
    localparam int NDS   = ns_to_cyc(T_DS_NS,  CLK_PERIOD_NS);
    localparam int NWR   = ns_to_cyc(T_WR_NS,  CLK_PERIOD_NS);
    localparam int NCYC  = ns_to_cyc(T_CYC_NS, CLK_PERIOD_NS);
    localparam int L_RD  = imax(imax(NACC - 1, NOE), 1);
    localparam int L_WR  = imax(imax(NWP, NDS - 1), 1);
    localparam int REC_R = imax(imax(NWR, NCYC - 1 - L_RD), 1);
    localparam int REC_W = imax(imax(NWR, NCYC - 1 - L_WR), 1);
    localparam int TW    = $clog2(L_RD + L_WR + REC_R + REC_W + 2);

    localparam logic [TW-1:0] LD_RD  = TW'(L_RD - 1);
    localparam logic [TW-1:0] LD_WR  = TW'(L_WR - 1);
    localparam logic [TW-1:0] LD_RCR = TW'(REC_R - 1);
    localparam logic [TW-1:0] LD_RCW = TW'(REC_W - 1);

    ctrl_state_e   state_q, state_nxt;
    logic          tmr_load, tmr_expired, sample, accept;
    logic [TW-1:0] tmr_val;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_ready && req_valid;

    sram_win_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    logic [DW-1:0] wdata_q;

    sram_bus_io #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .cap_addr  (req_addr),
        .cap_wdata (req_wdata),
        .sample    (sample),
        .dq_in     (sram_dq_i),
        .addr_q    (sram_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata),
        .rsp_q     (rsp_valid)
    );

    assign sram_dq_o = wdata_q;

    // Next state, timer loads and the sample strobe.
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sample    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_nxt = req_write ? S_WR_SETUP : S_RD_OPEN;
                end
            end
            S_RD_OPEN: begin
                state_nxt = S_RD_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = LD_RD;
            end
            S_RD_WAIT: begin
                if (tmr_expired) begin
                    state_nxt = S_RECOVER;
                    sample    = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RCR;
                end
            end
            S_WR_SETUP: begin
                state_nxt = S_WR_PULSE;
                tmr_load  = 1'b1;
                tmr_val   = LD_WR;
            end
            S_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nxt = S_RECOVER;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RCW;
                end
            end
            S_RECOVER: begin
                if (tmr_expired) begin
                    state_nxt = S_IDLE;
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Strobes registered from the next state so each pin is a flop output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            unique case (state_nxt)
                S_RD_OPEN: begin
                    sram_ce_n <= 1'b0; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b0;
                end
                S_RD_WAIT: begin
                    sram_ce_n <= 1'b0; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b0; sram_dq_oe <= 1'b0;
                end
                S_WR_SETUP: begin
                    sram_ce_n <= 1'b1; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b1;
                end
                S_WR_PULSE: begin
                    sram_ce_n <= 1'b0; sram_we_n <= 1'b0;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b1;
                end
                default: begin
                    sram_ce_n <= 1'b1; sram_we_n <= 1'b1;
                    sram_oe_n <= 1'b1; sram_dq_oe <= 1'b0;
                end
            endcase
        end
    end

    // R5: output enable never active while a write strobe is active.
    p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    // R6: drivers off whenever the memory may drive, and one cycle before.
    p_no_drive_under_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);
    p_drive_off_before_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> !$past(sram_dq_oe));

    // R4: address and data frozen while the write window is open.
    p_addr_stable_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !sram_we_n && $past(!sram_ce_n && !sram_we_n))
        |-> ($stable(sram_addr) && $stable(sram_dq_o)));

    // R8: acceptance always leaves the idle state.
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: response is a single pulse, issued once all strobes are released.
    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (sram_ce_n && sram_oe_n && !req_ready) ##1 !rsp_valid);

endmodule

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CLKNS = 8;
    localparam int N_ACC = cdiv(100, CLKNS);
    localparam int N_OE  = cdiv(50, CLKNS);
    localparam int N_WP  = cdiv(75, CLKNS);
    localparam int N_DS  = cdiv(40, CLKNS);
    localparam int N_WR  = cdiv(10, CLKNS);
    localparam int N_CYC = cdiv(100, CLKNS);
    localparam int E_LRD = mx(mx(N_ACC - 1, N_OE), 1);
    localparam int E_LWR = mx(mx(N_WP, N_DS - 1), 1);
    localparam int E_RCR = mx(mx(N_WR, N_CYC - 1 - E_LRD), 1);
    localparam int E_RCW = mx(mx(N_WR, N_CYC - 1 - E_LWR), 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [10:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_o, sram_dq_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_cycle_ctrl #(.CLK_PERIOD_NS(CLKNS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s act=%0d exp>=%0d", req, act, lim);
        end
    endtask

    task automatic flag(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    endtask

    // Memory model driven by the pins.
    logic [7:0] mem [0:2047];
    logic [7:0] shadow [0:2047];
    int   acc_cnt = 0, oe_cnt = 0, win_cnt = 0, ds_cnt = 0;
    int   rec_cnt = 1000, since_ce = 1000;
    logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_drv = 1'b0;
    logic [10:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    logic rd_ok = 1'b0;

    assign sram_dq_i = rd_ok ? mem[sram_addr] : ~mem[sram_addr];

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_oe_n && !sram_we_n) flag("R5 oe low during write", 0, 1);
            if (!sram_oe_n && sram_dq_oe) flag("R6 drive under oe", 1, 0);
            if (!sram_ce_n && !p_ce && sram_addr != p_addr)
                flag("R4 addr moved under ce", sram_addr, p_addr);
            // read window closes
            if (!p_oe && sram_oe_n) chk("R2 oe window length", oe_cnt, E_LRD);
            if (p_oe && !sram_oe_n) begin
                chk("R2 ce low before oe", p_ce, 0);
                chk("R6 drive off before oe", p_drv, 0);
            end
            // write window closes
            if (!p_ce && !p_we && !(!sram_ce_n && !sram_we_n)) begin
                chk("R4 write window length", win_cnt, E_LWR);
                chk_ge("R4 data setup", ds_cnt, N_DS);
                if (win_cnt >= N_WP && ds_cnt >= N_DS) mem[p_addr] = p_dq;
            end
            // cycle start
            if (p_ce && !sram_ce_n) begin
                chk_ge("R7 recovery", rec_cnt, N_WR);
                chk_ge("R7 cycle time", since_ce, N_CYC);
                since_ce = 0;
            end
            acc_cnt  = sram_ce_n ? 0 : acc_cnt + 1;
            oe_cnt   = sram_oe_n ? 0 : oe_cnt + 1;
            win_cnt  = (!sram_ce_n && !sram_we_n) ? win_cnt + 1 : 0;
            ds_cnt   = !sram_dq_oe ? 0 : ((p_drv && sram_dq_o == p_dq) ? ds_cnt + 1 : 1);
            rec_cnt  = (sram_ce_n && sram_we_n) ? rec_cnt + 1 : 0;
            since_ce = since_ce + 1;
            rd_ok    = !sram_ce_n && !sram_oe_n && sram_we_n &&
                       acc_cnt >= N_ACC && oe_cnt >= N_OE;
            p_ce = sram_ce_n; p_we = sram_we_n; p_oe = sram_oe_n;
            p_drv = sram_dq_oe; p_addr = sram_addr; p_dq = sram_dq_o;
        end
    end

    // Scoreboard.
    logic [7:0] exp_q [$];
    int         due_q [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                flag("R3 unexpected response", rsp_rdata, 0);
            end else begin
                chk("R3 R10 read data", rsp_rdata, exp_q.pop_front());
                chk("R3 response cycle", cyc, due_q.pop_front());
            end
        end
    end

    task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d,
                         input bit stray);
        int acc;
        int busy;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        acc = cyc;
        if (wr) shadow[a] = d;
        else begin
            exp_q.push_back(shadow[a]);
            due_q.push_back(acc + 1 + E_LRD);
        end
        @(negedge clk);
        if (stray) begin
            // R8: request while busy must be ignored
            req_valid = 1'b1; req_write = 1'b1; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(wr ? "R9 R7 write busy length" : "R9 R7 read busy length",
            busy, wr ? (1 + E_LWR + E_RCW) : (1 + E_LRD + E_RCR));
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]    = 8'(i) ^ 8'hA5;
            shadow[i] = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", req_ready, 1);
        chk("R1 ce in reset", sram_ce_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 strobes", {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        chk("R1 drive off", sram_dq_oe, 0);
        chk("R1 no response", rsp_valid, 0);

        issue(1'b1, 11'h000, 8'h3C, 1'b0);
        issue(1'b0, 11'h000, 8'h00, 1'b0);
        issue(1'b1, 11'h7FF, 8'hC3, 1'b0);
        issue(1'b0, 11'h7FF, 8'h00, 1'b0);
        issue(1'b0, 11'h123, 8'h00, 1'b0);
        issue(1'b1, 11'h555, 8'hFF, 1'b0);
        issue(1'b1, 11'h2AA, 8'h00, 1'b0);
        issue(1'b0, 11'h555, 8'h00, 1'b0);
        issue(1'b0, 11'h2AA, 8'h00, 1'b0);
        issue(1'b0, 11'h2AB, 8'h00, 1'b0);
        issue(1'b1, 11'h100, 8'h11, 1'b1);
        issue(1'b0, 11'h100, 8'h00, 1'b0);
        issue(1'b0, 11'h200, 8'h00, 1'b1);
        issue(1'b0, 11'h200, 8'h00, 1'b0);
        issue(1'b0, 11'h000, 8'h00, 1'b0);

        repeat (30) @(negedge clk);
        chk("R3 all responses returned", exp_q.size(), 0);
        chk("R8 idle at end", req_ready, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule